// File: doc/BRIEF.md
# Packed Unsigned Saturating Add/Subtract Unit

This block performs lane-parallel unsigned arithmetic on a 32-bit word. Two operand words are cut into independent lanes: either four byte lanes or two halfword lanes. Each lane is added or subtracted on its own. Instead of wrapping, every lane result is clamped to that lane's unsigned range. A sum that is too large becomes the lane's all-ones value. A difference below zero becomes zero.

The arithmetic uses a single segmented carry chain built from byte-wide adder slices. At every lane start the chain is cut and re-seeded, so no carry or borrow crosses from one lane into the next. The carry leaving the top slice of each lane decides whether that lane saturates. The packed result is captured in an output register, and an output valid flag is raised alongside it.

Top module: `psat_simd_unit`

## Requirements
- R1: With `size_half` = 0 the word forms four independent 8-bit lanes. Lane k takes operand bits [8k+7:8k] and writes its result to the same bits of `res_q`.
- R2: With `size_half` = 1 the word forms two independent 16-bit lanes. Lane 0 uses bits [15:0] and lane 1 uses bits [31:16], and each result goes back to the bits of its source lane.
- R3: With `op_sub` = 0 each lane outputs A + B. A sum above the lane maximum gives the maximum: 0xFF for byte lanes, 0xFFFF for halfword lanes.
- R4: With `op_sub` = 1 each lane outputs A − B, taking operand A's lane minus operand B's lane. A negative difference gives 0, so equal operands give 0.
- R5: No carry or borrow crosses a lane boundary. Saturation in one lane leaves the other lanes unchanged.
- R6: Operands and results are unsigned in all four combinations of `op_sub` and `size_half`.
- R7: In the clock cycle after `in_valid` is sampled high, `res_valid` is 1 and `res_q` holds the result. After a cycle with `in_valid` low, `res_valid` is 0 and `res_q` keeps its previous value.
- R8: A synchronous active-high `rst` clears both `res_q` and `res_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_sub | input | 1 | 0 = saturating add, 1 = saturating subtract |
| size_half | input | 1 | 0 = four byte lanes, 1 = two halfword lanes |
| opnd_a | input | 32 | First operand (minuend when subtracting) |
| opnd_b | input | 32 | Second operand (subtrahend when subtracting) |
| res_q | output | 32 | Registered packed lane results |
| res_valid | output | 1 | `res_q` was loaded by the previous cycle |

## Verification
The bench builds the unit with its default parameters: 32-bit data, 8-bit slices and two slices per wide lane. With these values both lane sizes exist, and the chain contains cut points that open or close depending on the mode. The cut between bits 7 and 8 acts as a lane boundary in byte mode but passes the carry in halfword mode. The same operands are therefore applied in both modes to show the carry being blocked in one and passed in the other. The bench also applies mixed words in which only some lanes saturate, and compares a pseudo-random sweep against a per-lane reference model.

// File: rtl/psat_pkg.sv
package psat_pkg;

   typedef enum logic {
      PSAT_ADD = 1'b0,
      PSAT_SUB = 1'b1
   } psat_op_e;

   typedef enum logic {
      PSAT_BYTE = 1'b0,
      PSAT_HALF = 1'b1
   } psat_size_e;

endpackage

// File: rtl/psat_seg_adder.sv
module psat_seg_adder #(
   parameter int SEG_W = 8
) (
   input  logic [SEG_W-1:0] seg_a,
   input  logic [SEG_W-1:0] seg_b,
   input  logic             invert_b,
   input  logic             carry_in,
   output logic [SEG_W-1:0] seg_sum,
   output logic             carry_out
);
   logic [SEG_W-1:0] b_eff;
   logic [SEG_W:0]   wide_sum;

   always_comb begin
      b_eff    = invert_b ? ~seg_b : seg_b;
      wide_sum = {1'b0, seg_a} + {1'b0, b_eff} + {{SEG_W{1'b0}}, carry_in};
   end

   assign seg_sum   = wide_sum[SEG_W-1:0];
   assign carry_out = wide_sum[SEG_W];
endmodule

// File: rtl/psat_carry_chain.sv
module psat_carry_chain
   import psat_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int SEG_W     = 8,
   parameter int HALF_SEGS = 2,
   localparam int NUM_SEG  = DATA_W / SEG_W
) (
   input  psat_op_e            op,
   input  psat_size_e          size,
   input  logic [DATA_W-1:0]   a,
   input  logic [DATA_W-1:0]   b,
   output logic [DATA_W-1:0]   raw_sum,
   output logic [NUM_SEG-1:0]  lane_carry
);
   logic [NUM_SEG-1:0] seg_cin;
   logic [NUM_SEG-1:0] seg_cout;
   logic               is_sub;
   logic               is_half;

   assign is_sub  = (op == PSAT_SUB);
   assign is_half = (size == PSAT_HALF);

   for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
      localparam bit WIDE_START = (s % HALF_SEGS) == 0;
      localparam int WIDE_TOP   = (s / HALF_SEGS) * HALF_SEGS + HALF_SEGS - 1;

      if (s == 0) begin : g_first
         assign seg_cin[s] = is_sub;
      end else if (WIDE_START) begin : g_cut
         assign seg_cin[s] = is_sub;
      end else begin : g_link
         // a narrow lane always starts here; a wide lane passes the carry on
         assign seg_cin[s] = is_half ? seg_cout[s-1] : is_sub;
      end

      psat_seg_adder #(.SEG_W(SEG_W)) u_add (
         .seg_a     (a[s*SEG_W +: SEG_W]),
         .seg_b     (b[s*SEG_W +: SEG_W]),
         .invert_b  (is_sub),
         .carry_in  (seg_cin[s]),
         .seg_sum   (raw_sum[s*SEG_W +: SEG_W]),
         .carry_out (seg_cout[s])
      );

      assign lane_carry[s] = is_half ? seg_cout[WIDE_TOP] : seg_cout[s];
   end
endmodule

// File: rtl/psat_saturate.sv
module psat_saturate
   import psat_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int SEG_W    = 8,
   localparam int NUM_SEG = DATA_W / SEG_W
) (
   input  psat_op_e            op,
   input  logic [DATA_W-1:0]   raw_sum,
   input  logic [NUM_SEG-1:0]  lane_carry,
   output logic [DATA_W-1:0]   clamped
);
   for (genvar s = 0; s < NUM_SEG; s++) begin : g_clamp
      logic ovf;
      logic unf;
      always_comb begin
         ovf = (op == PSAT_ADD) &  lane_carry[s];
         unf = (op == PSAT_SUB) & ~lane_carry[s];
         if (ovf)
            clamped[s*SEG_W +: SEG_W] = {SEG_W{1'b1}};
         else if (unf)
            clamped[s*SEG_W +: SEG_W] = '0;
         else
            clamped[s*SEG_W +: SEG_W] = raw_sum[s*SEG_W +: SEG_W];
      end
   end
endmodule

// File: rtl/psat_simd_unit.sv
module psat_simd_unit
   import psat_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int SEG_W     = 8,
   parameter int HALF_SEGS = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              op_sub,
   input  logic              size_half,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   output logic [DATA_W-1:0] res_q,
   output logic              res_valid
);
   localparam int NUM_SEG = DATA_W / SEG_W;
   localparam int WIDE_W  = SEG_W * HALF_SEGS;
   localparam int NUM_WIDE = DATA_W / WIDE_W;

   if (SEG_W < 1 || DATA_W % SEG_W != 0) begin : g_bad_seg
      $error("DATA_W must be a positive multiple of SEG_W");
   end
   if (HALF_SEGS < 1 || NUM_SEG % HALF_SEGS != 0) begin : g_bad_wide
      $error("slice count must be a multiple of HALF_SEGS");
   end

   psat_op_e            op_e;
   psat_size_e          size_e;
   logic [DATA_W-1:0]   raw_sum;
   logic [NUM_SEG-1:0]  lane_carry;
   logic [DATA_W-1:0]   lane_res;

   assign op_e   = psat_op_e'(op_sub);
   assign size_e = psat_size_e'(size_half);

   psat_carry_chain #(
      .DATA_W(DATA_W), .SEG_W(SEG_W), .HALF_SEGS(HALF_SEGS)
   ) u_chain (
      .op(op_e), .size(size_e), .a(opnd_a), .b(opnd_b),
      .raw_sum(raw_sum), .lane_carry(lane_carry)
   );

   psat_saturate #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_sat (
      .op(op_e), .raw_sum(raw_sum), .lane_carry(lane_carry), .clamped(lane_res)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         res_q     <= '0;
         res_valid <= 1'b0;
      end else begin
         res_valid <= in_valid;
         if (in_valid) res_q <= lane_res;
      end
   end

   // R7
   valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> res_valid);
   // R7
   valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !res_valid);
   // R4
   sub_equal_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_sub && opnd_a == opnd_b) |=> res_q == '0);

   for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg_chk
      // R3
      add_nodecr_chk: assert property (@(posedge clk) disable iff (rst)
         $past(!rst && in_valid && !op_sub && !size_half) |->
            (res_q[s*SEG_W +: SEG_W] >= $past(opnd_a[s*SEG_W +: SEG_W]) &&
             res_q[s*SEG_W +: SEG_W] >= $past(opnd_b[s*SEG_W +: SEG_W])));
      // R4
      sub_noincr_chk: assert property (@(posedge clk) disable iff (rst)
         $past(!rst && in_valid && op_sub && !size_half) |->
            res_q[s*SEG_W +: SEG_W] <= $past(opnd_a[s*SEG_W +: SEG_W]));
   end

   for (genvar w = 0; w < NUM_WIDE; w++) begin : g_wide_chk
      // R2
      wide_add_nodecr_chk: assert property (@(posedge clk) disable iff (rst)
         $past(!rst && in_valid && !op_sub && size_half) |->
            res_q[w*WIDE_W +: WIDE_W] >= $past(opnd_a[w*WIDE_W +: WIDE_W]));
   end
endmodule

// File: tb/psat_simd_unit_tb.sv
`timescale 1ns/1ps
module psat_simd_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic        op_sub;
   logic        size_half;
   logic [31:0] opnd_a;
   logic [31:0] opnd_b;
   logic [31:0] res_q;
   logic        res_valid;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   psat_simd_unit dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub),
      .size_half(size_half), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .res_q(res_q), .res_valid(res_valid)
   );

   // row layout: {op_sub, size_half, a, b, expected}
   localparam int NVEC = 14;
   localparam logic [97:0] VEC [NVEC] = '{
      {1'b0, 1'b0, 32'h01020304, 32'h10203040, 32'h11223344},
      {1'b0, 1'b0, 32'hFF00FF80, 32'h01000180, 32'hFF00FFFF},
      {1'b0, 1'b0, 32'h7F80FE01, 32'h01800101, 32'h80FFFF02},
      {1'b1, 1'b0, 32'h00050010, 32'h01030020, 32'h00020000},
      {1'b1, 1'b0, 32'hA5A5A5A5, 32'hA5A5A5A5, 32'h00000000},
      {1'b1, 1'b0, 32'h10FF0080, 32'h20010081, 32'h00FE0000},
      {1'b0, 1'b1, 32'hFFFF0001, 32'hFFFF0002, 32'hFFFF0003},
      {1'b0, 1'b1, 32'h00FF80FF, 32'h00010001, 32'h01008100},
      {1'b0, 1'b1, 32'h1234FFFF, 32'h11110001, 32'h2345FFFF},
      {1'b1, 1'b1, 32'h01000000, 32'h00010001, 32'h00FF0000},
      {1'b1, 1'b1, 32'h5A5A1234, 32'h5A5A1234, 32'h00000000},
      {1'b1, 1'b1, 32'h80000001, 32'h7FFF0002, 32'h00010000},
      {1'b0, 1'b0, 32'h00FF80FF, 32'h00010001, 32'h00FF80FF},
      {1'b1, 1'b0, 32'h01000000, 32'h00010001, 32'h01000000}
   };
   string vec_tag [NVEC] = '{
      "R1 R3", "R3 R5", "R3 R6", "R4 R5", "R4", "R4 R5", "R2 R3",
      "R2 R6", "R3 R5", "R2 R4", "R4", "R4 R5", "R1 R5", "R1 R4"
   };

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_calc(bit sub, bit half,
                                            logic [31:0] a, logic [31:0] b);
      logic [31:0] r = '0;
      int lw = half ? 16 : 8;
      int mx = half ? 65535 : 255;
      for (int k = 0; k < 32 / lw; k++) begin
         int x = int'((a >> (k * lw)) & 32'(mx));
         int y = int'((b >> (k * lw)) & 32'(mx));
         int v = sub ? x - y : x + y;
         if (v < 0) v = 0;
         if (v > mx) v = mx;
         r = r | (32'(v) << (k * lw));
      end
      return r;
   endfunction

   task automatic issue(bit sub, bit half, logic [31:0] a, logic [31:0] b);
      @(negedge clk);
      op_sub = sub; size_half = half; opnd_a = a; opnd_b = b; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      rst = 1'b1; in_valid = 1'b0; op_sub = 1'b0; size_half = 1'b0;
      opnd_a = '0; opnd_b = '0;
      repeat (3) @(negedge clk);
      // R8: reset state
      chk("R8 res_q", res_q, 32'h0);
      chk("R8 res_valid", 32'(res_valid), 32'h0);
      rst = 1'b0;

      for (int i = 0; i < NVEC; i++) begin
         issue(VEC[i][97], VEC[i][96], VEC[i][95:64], VEC[i][63:32]);
         chk({vec_tag[i], " R7 valid"}, 32'(res_valid), 32'h1);
         chk(vec_tag[i], res_q, VEC[i][31:0]);
      end

      // R7: result holds and valid drops when no new operands arrive
      @(negedge clk);
      opnd_a = 32'hFFFFFFFF; opnd_b = 32'hFFFFFFFF; op_sub = 1'b0;
      @(negedge clk);
      chk("R7 valid low", 32'(res_valid), 32'h0);
      chk("R7 hold", res_q, VEC[NVEC-1][31:0]);

      // R6 R1 R2: pseudo-random sweep against the lane model
      begin
         logic [31:0] lf = 32'hACE1_1234;
         for (int j = 0; j < 48; j++) begin
            logic [31:0] ra, rb;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            ra = lf ^ 32'h5A3C_96E1;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            rb = {lf[15:0], lf[31:16]};
            issue(j[0], j[1], ra, rb);
            chk("R6 sweep", res_q, ref_calc(j[0], j[1], ra, rb));
         end
      end

      // R8: reset clears a loaded result
      issue(1'b0, 1'b1, 32'h12345678, 32'h11111111);
      chk("R8 preload", res_q, 32'h23456789);
      rst = 1'b1;
      @(negedge clk);
      chk("R8 clear data", res_q, 32'h0);
      chk("R8 clear valid", 32'(res_valid), 32'h0);
      rst = 1'b0;

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule